// File: doc/BRIEF.md
# Event Timestamp Capture Bank

This block freezes the value of a free-running 64-bit nanosecond counter at the moment a precision-time event frame crosses the MAC. Received events that pass a programmable filter land in one of four lockable receive slots. Transmit events land in a single transmit latch that can raise an interrupt. The frame parser sits upstream and hands over only decoded tags: the protocol generation, whether the frame travelled over UDP or raw layer 2, and a 4-bit message type.

Software reaches the block through a small word-addressed register port. A read has its side effect at the clock edge that ends the read cycle. A stamp is 64 bits wide and is fetched as two 32-bit words, low first. Reading the high word of a slot releases that slot. The receive side reports the slot that took each stamp next to the frame, so the driver knows which pair of words to fetch.

Register map (word addresses): 0 enable (bit 0), 1 filter/control, 2 receive slot status, 3 event summary, 4 transmit low, 5 transmit high, 8+2k receive slot k low, 9+2k receive slot k high.

Top module: `tscap_bank`

## Requirements
- R1: With the enable bit (address 0, bit 0) clear, no receive or transmit event is captured. After reset every register reads zero and `tx_irq` is low.
- R2: An accepted receive event stores `cur_time` of its strobe cycle in the lowest-numbered free slot. Bit k of the status register (address 2) is set while slot k holds a locked stamp.
- R3: One cycle after an accepted receive strobe, `rx_stamped` pulses high and `rx_slot` carries the index of the slot that took the stamp. A rejected or dropped event leaves `rx_stamped` low.
- R4: Control register (address 1) layout: bits [1:0] select the generation (01 = first, 10 = second, other = none), bit 2 enables UDP recognition, bits [6:3] give the message type that must equal `rx_msg_type`, and bit 7 enables the transmit interrupt. In second-generation mode, layer-2 frames match without regard to bit 2, while UDP frames need bit 2 set.
- R5: In first-generation mode, only first-generation frames over UDP match, and only with bit 2 set. First-generation mode with bit 2 clear therefore captures nothing.
- R6: A locked slot keeps its stamp. If all slots are locked, an accepted event is dropped and bit 1 of the summary register (address 3) is set.
- R7: A read of a slot's high word alone clears that slot's lock and status bit. The next event may then reuse the slot.
- R8: A read of a low word (receive slot or transmit) snapshots the matching high half. The next high-word read returns that snapshot, even if a new stamp arrived between the two reads.
- R9: A transmit event stores `cur_time` only when the latch is empty, and the latch holds until its high word (address 5) is read. `tx_irq` is high while the latch is full and control bit 7 is set.
- R10: The summary register reads bit 0 = transmit stamp taken and bit 1 = receive overflow, and a read clears both bits.
- R11: A write to the control register replaces the filter fields and leaves the enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | 64 | Running nanosecond time |
| rx_evt | input | 1 | Receive event strobe |
| rx_is_v2 | input | 1 | Frame is second-generation |
| rx_is_udp | input | 1 | Frame carried over UDP (else layer 2) |
| rx_msg_type | input | 4 | Decoded message type |
| tx_evt | input | 1 | Transmit event strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the read cycle |
| rx_stamped | output | 1 | Receive stamp taken (one-cycle pulse) |
| rx_slot | output | 2 | Slot index of that stamp |
| tx_irq | output | 1 | Transmit stamp ready interrupt |

## Verification
Corrupted lock state has two visible results. A stamp that is overwritten shows up as a wrong low or high word on the next fetch. A lost lock bit shows up as a wrong `rx_slot` on the very next receive event, because allocation then picks a different lowest free slot. A filter decode error is visible one cycle after the strobe as a missing or extra `rx_stamped` pulse. Snapshot and clear-on-read faults appear on the read that follows the faulty one, which is why the scenarios interleave reads with new captures and always read the status and summary words back.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    localparam int A_ENABLE  = 0;
    localparam int A_CTRL    = 1;
    localparam int A_RXSTAT  = 2;
    localparam int A_EVT     = 3;
    localparam int A_TXLO    = 4;
    localparam int A_TXHI    = 5;
    localparam int SLOT_BASE = 8;

    typedef enum logic [1:0] {
        VER_NONE = 2'b00,
        VER_ONE  = 2'b01,
        VER_TWO  = 2'b10,
        VER_RSV  = 2'b11
    } ver_sel_e;

    // bit 7 irq enable, [6:3] message type, bit 2 udp enable, [1:0] generation
    typedef struct packed {
        logic       tx_irq_en;
        logic [3:0] msg_sel;
        logic       udp_en;
        ver_sel_e   ver;
    } filt_cfg_t;

    typedef struct packed {
        logic       is_v2;
        logic       is_udp;
        logic [3:0] msg;
    } frame_tag_t;

    function automatic logic frame_match(filt_cfg_t c, frame_tag_t f);
        logic ok;
        case (c.ver)
            VER_ONE: ok = !f.is_v2 && f.is_udp && c.udp_en;
            VER_TWO: ok = f.is_v2 && (!f.is_udp || c.udp_en);
            default: ok = 1'b0;
        endcase
        return ok && (f.msg == c.msg_sel);
    endfunction

endpackage

// File: rtl/tscap_rx_slots.sv
module tscap_rx_slots #(
    parameter int NSLOT  = 4,
    parameter int TIME_W = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(NSLOT)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cap_req,
    input  logic [TIME_W-1:0]              cap_time,
    input  logic [NSLOT-1:0]               rd_lo,
    input  logic [NSLOT-1:0]               rd_hi,
    output logic [NSLOT-1:0]               valid_o,
    output logic [NSLOT-1:0][DATA_W-1:0]   lo_o,
    output logic [NSLOT-1:0][TIME_W-DATA_W-1:0] hi_o,
    output logic                           cap_ok_o,
    output logic [IDX_W-1:0]               cap_idx_o,
    output logic                           drop_o
);
    localparam int HI_W = TIME_W - DATA_W;

    logic [NSLOT-1:0]             valid_q;
    logic [NSLOT-1:0][TIME_W-1:0] stamp_q;
    logic [NSLOT-1:0][HI_W-1:0]   shadow_q;
    logic [NSLOT-1:0]             sel;
    logic [IDX_W-1:0]             pick;
    logic                         any_free;

    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                any_free = 1'b1;
                pick     = IDX_W'(i);
            end
        end
        sel = (cap_req && any_free) ? (NSLOT'(1) << pick) : '0;
    end

    assign drop_o = cap_req && !any_free;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g]  <= 1'b0;
                stamp_q[g]  <= '0;
                shadow_q[g] <= '0;
            end else begin
                if (sel[g]) begin
                    valid_q[g] <= 1'b1;
                    stamp_q[g] <= cap_time;
                end else if (rd_hi[g]) begin
                    valid_q[g] <= 1'b0;
                end
                if (rd_lo[g])
                    shadow_q[g] <= stamp_q[g][TIME_W-1:DATA_W];
            end
        end
        assign lo_o[g] = stamp_q[g][DATA_W-1:0];
        assign hi_o[g] = shadow_q[g];

        assert_slot_locked_R6: assert property (@(posedge clk) disable iff (rst)
            (valid_q[g] && !rd_hi[g]) |=> (valid_q[g] && $stable(stamp_q[g])));
        assert_hi_frees_R7: assert property (@(posedge clk) disable iff (rst)
            rd_hi[g] |=> !valid_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ok_o  <= 1'b0;
            cap_idx_o <= '0;
        end else begin
            cap_ok_o  <= cap_req && any_free;
            cap_idx_o <= pick;
        end
    end

    assign valid_o = valid_q;

    assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (cap_req && (&valid_q)) |=> !cap_ok_o);
endmodule

// File: rtl/tscap_tx_latch.sv
module tscap_tx_latch #(
    parameter int TIME_W = 64,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cap_req,
    input  logic [TIME_W-1:0]        cap_time,
    input  logic                     rd_lo,
    input  logic                     rd_hi,
    output logic                     full_o,
    output logic                     new_o,
    output logic [DATA_W-1:0]        lo_o,
    output logic [TIME_W-DATA_W-1:0] hi_o
);
    localparam int HI_W = TIME_W - DATA_W;

    logic              full_q;
    logic [TIME_W-1:0] stamp_q;
    logic [HI_W-1:0]   shadow_q;

    assign new_o = cap_req && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= 1'b0;
            stamp_q  <= '0;
            shadow_q <= '0;
        end else begin
            if (new_o) begin
                full_q  <= 1'b1;
                stamp_q <= cap_time;
            end else if (rd_hi) begin
                full_q <= 1'b0;
            end
            if (rd_lo)
                shadow_q <= stamp_q[TIME_W-1:DATA_W];
        end
    end

    assign full_o = full_q;
    assign lo_o   = stamp_q[DATA_W-1:0];
    assign hi_o   = shadow_q;

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (full_q && !rd_hi) |=> (full_q && $stable(stamp_q)));
endmodule

// File: rtl/tscap_bank.sv
module tscap_bank
    import tscap_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int TIME_W = 64,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              rx_evt,
    input  logic              rx_is_v2,
    input  logic              rx_is_udp,
    input  logic [3:0]        rx_msg_type,
    input  logic              tx_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_stamped,
    output logic [IDX_W-1:0]  rx_slot,
    output logic              tx_irq
);
    localparam int HI_W  = TIME_W - DATA_W;
    localparam int CFG_W = $bits(filt_cfg_t);

    logic       en_q;
    filt_cfg_t  cfg_q;
    logic       evt_tx_q, evt_ovf_q;
    frame_tag_t tag;
    logic       rx_hit, tx_req;

    logic [NSLOT-1:0]             rd_lo, rd_hi, slot_valid;
    logic [NSLOT-1:0][DATA_W-1:0] slot_lo;
    logic [NSLOT-1:0][HI_W-1:0]   slot_hi;
    logic                         drop;
    logic                         tx_full, tx_new;
    logic [DATA_W-1:0]            tx_lo;
    logic [HI_W-1:0]              tx_hi;

    function automatic logic at(logic [ADDR_W-1:0] a, int n);
        return a == ADDR_W'(n);
    endfunction

    assign tag    = '{is_v2: rx_is_v2, is_udp: rx_is_udp, msg: rx_msg_type};
    assign rx_hit = en_q && rx_evt && frame_match(cfg_q, tag);
    assign tx_req = en_q && tx_evt;

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        assign rd_lo[g] = reg_rd && at(reg_addr, SLOT_BASE + 2 * g);
        assign rd_hi[g] = reg_rd && at(reg_addr, SLOT_BASE + 2 * g + 1);
    end

    tscap_rx_slots #(.NSLOT(NSLOT), .TIME_W(TIME_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_slots (
        .clk(clk), .rst(rst), .cap_req(rx_hit), .cap_time(cur_time),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .valid_o(slot_valid), .lo_o(slot_lo), .hi_o(slot_hi),
        .cap_ok_o(rx_stamped), .cap_idx_o(rx_slot), .drop_o(drop)
    );

    tscap_tx_latch #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .cap_req(tx_req), .cap_time(cur_time),
        .rd_lo(reg_rd && at(reg_addr, A_TXLO)), .rd_hi(reg_rd && at(reg_addr, A_TXHI)),
        .full_o(tx_full), .new_o(tx_new), .lo_o(tx_lo), .hi_o(tx_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            cfg_q     <= '0;
            evt_tx_q  <= 1'b0;
            evt_ovf_q <= 1'b0;
        end else begin
            if (reg_wr && at(reg_addr, A_ENABLE))
                en_q <= reg_wdata[0];
            if (reg_wr && at(reg_addr, A_CTRL))
                cfg_q <= filt_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (tx_new)
                evt_tx_q <= 1'b1;
            else if (reg_rd && at(reg_addr, A_EVT))
                evt_tx_q <= 1'b0;
            if (drop)
                evt_ovf_q <= 1'b1;
            else if (reg_rd && at(reg_addr, A_EVT))
                evt_ovf_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (at(reg_addr, A_ENABLE))      reg_rdata[0] = en_q;
        else if (at(reg_addr, A_CTRL))   reg_rdata[CFG_W-1:0] = cfg_q;
        else if (at(reg_addr, A_RXSTAT)) reg_rdata[NSLOT-1:0] = slot_valid;
        else if (at(reg_addr, A_EVT))    reg_rdata[1:0] = {evt_ovf_q, evt_tx_q};
        else if (at(reg_addr, A_TXLO))   reg_rdata = tx_lo;
        else if (at(reg_addr, A_TXHI))   reg_rdata = DATA_W'(tx_hi);
        for (int i = 0; i < NSLOT; i++) begin
            if (at(reg_addr, SLOT_BASE + 2 * i))     reg_rdata = slot_lo[i];
            if (at(reg_addr, SLOT_BASE + 2 * i + 1)) reg_rdata = DATA_W'(slot_hi[i]);
        end
    end

    assign tx_irq = tx_full && cfg_q.tx_irq_en;

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && at(reg_addr, A_TXHI)) |=> !tx_irq);
    assert_evt_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && at(reg_addr, A_EVT) && !tx_new && !drop) |=> (!evt_tx_q && !evt_ovf_q));
    assert_ctrl_keeps_en_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && at(reg_addr, A_CTRL)) |=> $stable(en_q));
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !rx_stamped);
endmodule

// File: tb/tscap_bank_bench.sv
module tscap_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cur_time = '0;
    logic        rx_evt = 0, rx_is_v2 = 0, rx_is_udp = 0, tx_evt = 0;
    logic [3:0]  rx_msg_type = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_stamped, tx_irq;
    logic [1:0]  rx_slot;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    tscap_bank u_tscap_bank (
        .clk(clk), .rst(rst), .cur_time(cur_time), .rx_evt(rx_evt), .rx_is_v2(rx_is_v2),
        .rx_is_udp(rx_is_udp), .rx_msg_type(rx_msg_type), .tx_evt(tx_evt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_stamped(rx_stamped), .rx_slot(rx_slot), .tx_irq(tx_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected word for each read cycle
    always @(negedge clk) begin
        if (reg_rd && q_exp.size() > 0) begin
            automatic logic [31:0] e = q_exp.pop_front();
            automatic string t = q_tag.pop_front();
            check(t, reg_rdata, e);
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        reg_rd = 1; reg_addr = 4'(a);
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic rx_fire(logic [63:0] t, logic v2, logic udp, logic [3:0] m,
                           logic exp_ok, logic [1:0] exp_idx, string tag);
        @(posedge clk); #1;
        cur_time = t; rx_evt = 1; rx_is_v2 = v2; rx_is_udp = udp; rx_msg_type = m;
        @(posedge clk); #1;
        rx_evt = 0;
        @(negedge clk);
        check({tag, " stamped"}, 32'(rx_stamped), 32'(exp_ok));
        if (exp_ok) check({tag, " slot"}, 32'(rx_slot), 32'(exp_idx));
    endtask

    task automatic tx_fire(logic [63:0] t);
        @(posedge clk); #1;
        cur_time = t; tx_evt = 1;
        @(posedge clk); #1;
        tx_evt = 0;
    endtask

    localparam logic [63:0] TA = 64'h0000_0011_0000_0100;
    localparam logic [63:0] TB = 64'h0000_0022_0000_0200;
    localparam logic [63:0] TC = 64'h0000_0033_0000_0300;
    localparam logic [63:0] TD = 64'h0000_0044_0000_0400;
    localparam logic [63:0] TE = 64'h0000_0055_0000_0500;
    localparam logic [63:0] TF = 64'h0000_0066_0000_0600;
    localparam logic [63:0] TG = 64'h0000_0077_0000_0700;
    localparam logic [63:0] TH = 64'h0000_0088_0000_0800;
    localparam logic [63:0] T1 = 64'h0000_0101_0000_1001;
    localparam logic [63:0] T2 = 64'h0000_0202_0000_2002;
    localparam logic [63:0] T3 = 64'h0000_0303_0000_3003;

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 reset irq", 32'(tx_irq), 0);
        rd(0, 0, "R1 reset enable");
        rd(2, 0, "R1 reset status");
        rd(3, 0, "R1 reset summary");

        // filter programmed but block disabled
        wr(1, 32'h86);
        rx_fire(TA, 1, 1, 0, 0, 0, "R1 disabled rx");
        rd(2, 0, "R1 disabled status");

        wr(0, 1);
        wr(1, 32'h86);
        rd(0, 1, "R11 enable kept");
        rd(1, 32'h86, "R11 ctrl readback");

        rx_fire(TA, 1, 1, 0, 1, 0, "R2 R3 first");
        rx_fire(TB, 1, 0, 0, 1, 1, "R4 v2 l2");
        rd(2, 32'h3, "R2 status two");
        rx_fire(TE, 0, 1, 0, 0, 0, "R4 v1 in v2 mode");
        rx_fire(TE, 1, 1, 3, 0, 0, "R4 msg mismatch");
        rd(2, 32'h3, "R4 status unchanged");

        rx_fire(TC, 1, 1, 0, 1, 2, "R3 third");
        rx_fire(TD, 1, 0, 0, 1, 3, "R3 fourth");
        rd(2, 32'hF, "R2 status full");
        rx_fire(TE, 1, 1, 0, 0, 0, "R6 dropped");
        rd(3, 32'h2, "R6 overflow flag");
        rd(3, 32'h0, "R10 summary cleared");
        rd(12, TC[31:0], "R6 slot2 lo kept");
        rd(13, TC[63:32], "R6 slot2 hi kept");
        rd(2, 32'hB, "R7 slot2 freed");

        rd(10, TB[31:0], "R2 slot1 lo");
        rd(11, TB[63:32], "R2 slot1 hi");
        rd(2, 32'h9, "R7 slot1 freed");
        rx_fire(TF, 1, 1, 0, 1, 1, "R7 reuse lowest");

        rd(9, 32'h0, "R7 hi-only read snapshot");
        rd(2, 32'hA, "R7 hi-only frees");

        rd(8, TA[31:0], "R8 free slot0 lo");
        rx_fire(TG, 1, 1, 0, 1, 0, "R8 capture between");
        rd(9, TA[63:32], "R8 hi from snapshot");
        rd(8, TG[31:0], "R8 new lo");
        rd(9, TG[63:32], "R8 new hi");
        rd(10, TF[31:0], "R7 reused lo");
        rd(11, TF[63:32], "R7 reused hi");
        rd(2, 32'h8, "R7 status after reads");

        wr(1, 32'h81);
        rd(0, 1, "R11 enable after ctrl");
        rx_fire(TH, 0, 1, 0, 0, 0, "R5 v1 udp off");
        wr(1, 32'h85);
        rx_fire(TH, 0, 0, 0, 0, 0, "R5 v1 l2");
        rx_fire(TH, 0, 1, 0, 1, 0, "R5 v1 udp on");
        rd(8, TH[31:0], "R5 stamp lo");

        tx_fire(T1);
        @(negedge clk);
        check("R9 irq raised", 32'(tx_irq), 1);
        rd(3, 32'h1, "R10 tx flag");
        tx_fire(T2);
        rd(4, T1[31:0], "R9 first kept lo");
        rd(5, T1[63:32], "R9 first kept hi");
        @(negedge clk);
        check("R9 irq cleared", 32'(tx_irq), 0);
        wr(1, 32'h05);
        tx_fire(T3);
        @(negedge clk);
        check("R9 irq masked", 32'(tx_irq), 0);
        rd(4, T3[31:0], "R9 new lo");
        rd(5, T3[63:32], "R9 new hi");
        rd(3, 32'h1, "R10 tx flag again");

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule